// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a 9-bit first-in first-out buffer that joins two unrelated clock domains. A producer writes on its own free-running clock, and only when two separate write enables are high together. A consumer reads on a second free-running clock that need not share phase or frequency with the first. The head word shows on the read bus as soon as it has crossed into the read domain (show-ahead), so no priming read is needed. A read request then drops the head and moves to the next word.

Four status flags describe the fill level. The buffer is empty, full, almost empty (fill at or below a lower offset) or almost full (fill at or above depth minus an upper offset). Both offsets can be loaded at run time through a small parallel port, and reset returns both to seven. An output enable masks the read bus and its valid flag. Depth is a power-of-two parameter from 64 to 4096 words.

Top module: `xclk_fifo`

## Requirements
- R1: A word is stored on a rising wrClk edge only when wrEnA and wrEnB are both 1 and full is 0; a cycle with only one of them high stores nothing.
- R2: With outEn=1, the first word written into an empty buffer appears on rdData with rdValid=1 and empty=0 within a few rdClk cycles, without any rdEn pulse.
- R3: Words leave in the order they were written; a rising rdClk edge with rdEn=1 and empty=0 removes the head, and rdData then shows the next word.
- R4: full is 1 exactly when DEPTH words are held; a write attempted while full is dropped and leaves the stored contents and their order unchanged.
- R5: A read request while empty is ignored: it moves no pointer, and the next word written is the next word read.
- R6: empty is 1 exactly when the read side sees no stored words.
- R7: almostEmpty is 1 when the fill level seen by the read side is less than or equal to the lower offset (default 7: 1 at 7 words, 0 at 8).
- R8: almostFull is 1 when the fill level seen by the write side is greater than or equal to DEPTH minus the upper offset (default 7: with DEPTH=64, 0 at 56 words, 1 at 57).
- R9: A wrClk edge with offLoad=1 loads offData into the lower offset when offSel=0, or into the upper offset when offSel=1. The load takes effect only when the write side sees an empty buffer and no write is requested in that cycle; otherwise it is ignored.
- R10: When outEn=0, rdValid is 0 and rdData is 0. When outEn=1, rdValid equals the inverse of empty, and rdData is 0 while rdValid is 0.
- R11: An asynchronous reset (rstN=0) empties the buffer (empty=1, almostEmpty=1, full=0, almostFull=0) and sets both offsets back to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock, independent of wrClk |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrEnA | input | 1 | First write enable |
| wrEnB | input | 1 | Second write enable; both must be high to write |
| wrData | input | 9 | Word to store |
| rdEn | input | 1 | Removes the head word on a rising rdClk edge |
| outEn | input | 1 | Read bus enable; 0 masks rdData and rdValid |
| rdData | output | 9 | Head word of the buffer (show-ahead) |
| rdValid | output | 1 | rdData holds a real word |
| empty | output | 1 | No words visible to the read side |
| full | output | 1 | DEPTH words held, as seen by the write side |
| almostEmpty | output | 1 | Read-side fill is at or below the lower offset |
| almostFull | output | 1 | Write-side fill is at or above DEPTH minus the upper offset |
| offLoad | input | 1 | Offset load strobe, sampled on wrClk |
| offSel | input | 1 | 0 selects the lower offset, 1 the upper offset |
| offData | input | $clog2(DEPTH) | Offset value to load |

## Verification
The bench fills the buffer to exactly DEPTH and then pushes one extra word. If that overflow is not blocked, the wrapped pointer makes full drop and corrupts the drain order. It also reads from an empty buffer: a design that lets the read pointer move there reports a non-empty buffer holding garbage once the next word arrives. The almost-flag edges are checked one word either side of the default and of loaded thresholds, which catches off-by-one comparisons. A load attempted while words are held must leave the threshold unchanged. Writes with only one enable high must store nothing, and a reset must restore both offsets to seven.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

  // Reset value of both programmable offsets.
  localparam int unsigned OFF_DEFAULT = 7;

  // Write-domain strobes from the control to the datapath.
  typedef struct packed {
    logic push;          // store wrData at wrAddr
    logic loadLowOff;    // take offData into the lower offset
    logic loadHighOff;   // take offData into the upper offset
  } fifoStrobe_t;

endpackage

// File: rtl/xclk_fifo_sync.sv
module xclk_fifo_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= dIn;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign dOut = chain[STAGES-1];

endmodule

// File: rtl/xclk_fifo_ctrl.sv
module xclk_fifo_ctrl
  import xclk_fifo_pkg::*;
#(
  parameter int unsigned DEPTH       = 512,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          wrEnA,
  input  logic          wrEnB,
  input  logic          rdEn,
  input  logic          offLoad,
  input  logic          offSel,
  input  logic [AW-1:0] lowOff,
  input  logic [AW-1:0] highOff,
  output fifoStrobe_t   strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          empty,
  output logic          full,
  output logic          almostEmpty,
  output logic          almostFull
);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PW-1:0] wrBin, wrGray, rdGraySynced, rdBinSeen, wrCount;
  logic          bothEn;

  xclk_fifo_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_rdToWr (
    .clk (wrClk),
    .rstN(rstN),
    .dIn (rdGray),
    .dOut(rdGraySynced)
  );

  always_comb begin
    bothEn       = wrEnA & wrEnB;
    rdBinSeen    = fromGray(rdGraySynced);
    wrCount      = wrBin - rdBinSeen;
    full         = (wrCount == PW'(DEPTH));
    almostFull   = (wrCount >= (PW'(DEPTH) - PW'(highOff)));
    strobe.push  = bothEn & ~full;
    strobe.loadLowOff  = offLoad & ~offSel & ~bothEn & (wrCount == '0);
    strobe.loadHighOff = offLoad &  offSel & ~bothEn & (wrCount == '0);
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (strobe.push) begin
      wrBin  <= wrBin + 1'b1;
      wrGray <= toGray(wrBin + 1'b1);
    end
  end

  assign wrAddr = wrBin[AW-1:0];

  // ---------------- read domain ----------------
  logic [PW-1:0] rdBin, rdGray, wrGraySynced, wrBinSeen, rdCount;
  logic          pop;

  xclk_fifo_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_wrToRd (
    .clk (rdClk),
    .rstN(rstN),
    .dIn (wrGray),
    .dOut(wrGraySynced)
  );

  always_comb begin
    wrBinSeen   = fromGray(wrGraySynced);
    rdCount     = wrBinSeen - rdBin;
    empty       = (rdCount == '0);
    almostEmpty = (rdCount <= {1'b0, lowOff});
    pop         = rdEn & ~empty;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (pop) begin
      rdBin  <= rdBin + 1'b1;
      rdGray <= toGray(rdBin + 1'b1);
    end
  end

  assign rdAddr = rdBin[AW-1:0];

endmodule

// File: rtl/xclk_fifo_dpath.sv
module xclk_fifo_dpath
  import xclk_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned WIDTH = 9,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             wrClk,
  input  logic             rstN,
  input  fifoStrobe_t      strobe,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [AW-1:0]    offData,
  input  logic             outEn,
  input  logic             empty,
  output logic [AW-1:0]    lowOff,
  output logic [AW-1:0]    highOff,
  output logic [WIDTH-1:0] rdData,
  output logic             rdValid
);

  logic [WIDTH-1:0] store [DEPTH];
  logic [WIDTH-1:0] headWord;

  always_ff @(posedge wrClk) begin
    if (strobe.push) begin
      store[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      lowOff  <= AW'(OFF_DEFAULT);
      highOff <= AW'(OFF_DEFAULT);
    end else begin
      if (strobe.loadLowOff)  lowOff  <= offData;
      if (strobe.loadHighOff) highOff <= offData;
    end
  end

  always_comb begin
    headWord = store[rdAddr];
    rdValid  = outEn & ~empty;
    rdData   = rdValid ? headWord : '0;
  end

endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
  import xclk_fifo_pkg::*;
#(
  parameter int unsigned DEPTH       = 512,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     wrClk,
  input  logic                     rdClk,
  input  logic                     rstN,
  input  logic                     wrEnA,
  input  logic                     wrEnB,
  input  logic [8:0]               wrData,
  input  logic                     rdEn,
  input  logic                     outEn,
  output logic [8:0]               rdData,
  output logic                     rdValid,
  output logic                     empty,
  output logic                     full,
  output logic                     almostEmpty,
  output logic                     almostFull,
  input  logic                     offLoad,
  input  logic                     offSel,
  input  logic [$clog2(DEPTH)-1:0] offData
);

  localparam int unsigned AW = $clog2(DEPTH);

  fifoStrobe_t   strobe;
  logic [AW-1:0] wrAddr, rdAddr, lowOff, highOff;

  xclk_fifo_ctrl #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .wrClk      (wrClk),
    .rdClk      (rdClk),
    .rstN       (rstN),
    .wrEnA      (wrEnA),
    .wrEnB      (wrEnB),
    .rdEn       (rdEn),
    .offLoad    (offLoad),
    .offSel     (offSel),
    .lowOff     (lowOff),
    .highOff    (highOff),
    .strobe     (strobe),
    .wrAddr     (wrAddr),
    .rdAddr     (rdAddr),
    .empty      (empty),
    .full       (full),
    .almostEmpty(almostEmpty),
    .almostFull (almostFull)
  );

  xclk_fifo_dpath #(.DEPTH(DEPTH), .WIDTH(9)) u_dpath (
    .wrClk  (wrClk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .wrData (wrData),
    .offData(offData),
    .outEn  (outEn),
    .empty  (empty),
    .lowOff (lowOff),
    .highOff(highOff),
    .rdData (rdData),
    .rdValid(rdValid)
  );

endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk (
  input logic wrClk,
  input logic rdClk,
  input logic rstN,
  input logic wrEnA,
  input logic wrEnB,
  input logic rdEn,
  input logic outEn,
  input logic rdValid,
  input logic empty,
  input logic full,
  input logic almostEmpty,
  input logic almostFull
);

  // full can only come up after a write attempt on the previous edge
  assert_full_needs_write_R4: assert property (@(posedge wrClk) disable iff (!rstN)
    $rose(full) |-> $past(wrEnA && wrEnB));

  // the buffer can only become empty through a read
  assert_empty_needs_read_R6: assert property (@(posedge rdClk) disable iff (!rstN)
    $rose(empty) |-> $past(rdEn));

  // empty implies almost empty
  assert_empty_implies_low_R7: assert property (@(posedge rdClk) disable iff (!rstN)
    empty |-> almostEmpty);

  // almost empty only rises through reads
  assert_low_needs_read_R7: assert property (@(posedge rdClk) disable iff (!rstN)
    $rose(almostEmpty) |-> $past(rdEn));

  // full implies almost full
  assert_full_implies_high_R8: assert property (@(posedge wrClk) disable iff (!rstN)
    full |-> almostFull);

  // almost full only rises through writes
  assert_high_needs_write_R8: assert property (@(posedge wrClk) disable iff (!rstN)
    $rose(almostFull) |-> $past(wrEnA && wrEnB));

  // a valid word never shows while empty or while masked
  assert_valid_not_empty_R10: assert property (@(posedge rdClk) disable iff (!rstN)
    rdValid |-> (!empty && outEn));

endmodule

bind xclk_fifo xclk_fifo_chk u_chk (
  .wrClk      (wrClk),
  .rdClk      (rdClk),
  .rstN       (rstN),
  .wrEnA      (wrEnA),
  .wrEnB      (wrEnB),
  .rdEn       (rdEn),
  .outEn      (outEn),
  .rdValid    (rdValid),
  .empty      (empty),
  .full       (full),
  .almostEmpty(almostEmpty),
  .almostFull (almostFull)
);

// File: tb/tb_xclk_fifo.sv
`timescale 1ns/1ps
module tb_xclk_fifo;

  localparam int unsigned DEPTH = 64;
  localparam int unsigned AW    = $clog2(DEPTH);

  logic          wrClk = 0, rdClk = 0, rstN = 0;
  logic          wrEnA = 0, wrEnB = 0, rdEn = 0, outEn = 1;
  logic [8:0]    wrData = '0;
  logic [8:0]    rdData;
  logic          rdValid, empty, full, almostEmpty, almostFull;
  logic          offLoad = 0, offSel = 0;
  logic [AW-1:0] offData = '0;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2 wrClk = ~wrClk;   // 250 MHz
  always #3 rdClk = ~rdClk;   // unrelated read clock

  xclk_fifo #(.DEPTH(DEPTH)) dut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEnA(wrEnA), .wrEnB(wrEnB), .wrData(wrData),
    .rdEn(rdEn), .outEn(outEn), .rdData(rdData), .rdValid(rdValid),
    .empty(empty), .full(full), .almostEmpty(almostEmpty), .almostFull(almostFull),
    .offLoad(offLoad), .offSel(offSel), .offData(offData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    check(act == exp, req, what, act, exp);
  endtask

  task automatic doReset();
    rstN = 0;
    repeat (4) @(negedge rdClk);
    rstN = 1;
    repeat (3) @(negedge rdClk);
  endtask

  task automatic settle();
    repeat (6) @(negedge rdClk);
  endtask

  task automatic pushWord(input logic [8:0] d, input bit a = 1, input bit b = 1);
    @(negedge wrClk);
    wrEnA = a; wrEnB = b; wrData = d;
    @(negedge wrClk);
    wrEnA = 0; wrEnB = 0;
  endtask

  task automatic popWord();
    @(negedge rdClk);
    rdEn = 1;
    @(negedge rdClk);
    rdEn = 0;
  endtask

  task automatic loadOff(input bit sel, input int val);
    @(negedge wrClk);
    offLoad = 1; offSel = sel; offData = AW'(val);
    @(negedge wrClk);
    offLoad = 0;
  endtask

  task automatic testReset();
    doReset();
    checkEq("R11", "empty after reset", empty, 1);
    checkEq("R11", "almostEmpty after reset", almostEmpty, 1);
    checkEq("R11", "full after reset", full, 0);
    checkEq("R11", "almostFull after reset", almostFull, 0);
    checkEq("R10", "rdValid while empty", rdValid, 0);
    checkEq("R10", "rdData while empty", rdData, 0);
  endtask

  task automatic testSingleEnable();
    doReset();
    pushWord(9'h011, 1, 0);
    pushWord(9'h022, 0, 1);
    settle();
    checkEq("R1", "empty after single-enable writes", empty, 1);
    pushWord(9'h033);
    settle();
    checkEq("R1", "empty after dual-enable write", empty, 0);
    checkEq("R1", "stored word", rdData, 9'h033);
  endtask

  task automatic testFallThrough();
    doReset();
    pushWord(9'h1A5);
    settle();
    checkEq("R2", "rdValid without read", rdValid, 1);
    checkEq("R2", "head word without read", rdData, 9'h1A5);
    checkEq("R6", "empty with one word", empty, 0);
    popWord();
    settle();
    checkEq("R6", "empty after last read", empty, 1);
  endtask

  task automatic testOrder();
    logic [8:0] pat [5];
    pat[0] = 9'h155; pat[1] = 9'h0AA; pat[2] = 9'h000; pat[3] = 9'h1FF; pat[4] = 9'h123;
    doReset();
    for (int i = 0; i < 5; i++) pushWord(pat[i]);
    settle();
    for (int i = 0; i < 5; i++) begin
      checkEq("R3", $sformatf("order word %0d", i), rdData, pat[i]);
      popWord();
    end
    settle();
    checkEq("R3", "empty after drain", empty, 1);
  endtask

  task automatic testReadEmpty();
    doReset();
    popWord(); popWord(); popWord();
    settle();
    checkEq("R5", "empty after reads while empty", empty, 1);
    pushWord(9'h055);
    settle();
    checkEq("R5", "word after ignored reads", rdData, 9'h055);
    popWord();
    settle();
    checkEq("R5", "empty after one read", empty, 1);
  endtask

  task automatic testFillDefaults();
    doReset();
    for (int i = 0; i < DEPTH; i++) begin
      pushWord(9'(i));
      if (i + 1 == 7 || i + 1 == 8 || i + 1 == 56 || i + 1 == 57) begin
        settle();
        case (i + 1)
          7:  checkEq("R7", "almostEmpty at 7", almostEmpty, 1);
          8:  checkEq("R7", "almostEmpty at 8", almostEmpty, 0);
          56: checkEq("R8", "almostFull at 56", almostFull, 0);
          default: checkEq("R8", "almostFull at 57", almostFull, 1);
        endcase
        checkEq("R4", "full before DEPTH", full, 0);
      end
    end
    settle();
    checkEq("R4", "full at DEPTH", full, 1);
    checkEq("R8", "almostFull at DEPTH", almostFull, 1);
    pushWord(9'h1FF);
    settle();
    checkEq("R4", "full after overflow attempt", full, 1);
    for (int i = 0; i < DEPTH; i++) begin
      if (rdData != 9'(i) || rdValid != 1)
        checkEq("R4", $sformatf("drain word %0d", i), rdData, i);
      popWord();
    end
    total++;
    settle();
    checkEq("R4", "empty after draining DEPTH words", empty, 1);
    checkEq("R4", "full after drain", full, 0);
  endtask

  task automatic testOffsets();
    doReset();
    loadOff(0, 20);
    loadOff(1, 10);
    for (int i = 0; i < 20; i++) pushWord(9'(i));
    settle();
    checkEq("R9", "almostEmpty at loaded 20", almostEmpty, 1);
    pushWord(9'h100);
    settle();
    checkEq("R9", "almostEmpty at 21", almostEmpty, 0);
    loadOff(0, 40);
    settle();
    checkEq("R9", "load while non-empty ignored", almostEmpty, 0);
    for (int i = 0; i < 32; i++) pushWord(9'(i));
    settle();
    checkEq("R9", "almostFull at 53 with offset 10", almostFull, 0);
    pushWord(9'h101);
    settle();
    checkEq("R9", "almostFull at 54 with offset 10", almostFull, 1);
    doReset();
    for (int i = 0; i < 7; i++) pushWord(9'(i));
    settle();
    checkEq("R11", "lower offset back to 7 (at 7)", almostEmpty, 1);
    pushWord(9'h0);
    settle();
    checkEq("R11", "lower offset back to 7 (at 8)", almostEmpty, 0);
  endtask

  task automatic testOutEn();
    doReset();
    pushWord(9'h0C3);
    settle();
    outEn = 0;
    #1;
    checkEq("R10", "rdValid masked", rdValid, 0);
    checkEq("R10", "rdData masked", rdData, 0);
    outEn = 1;
    #1;
    checkEq("R10", "rdValid unmasked", rdValid, 1);
    checkEq("R10", "rdData unmasked", rdData, 9'h0C3);
  endtask

  initial begin
    testReset();
    testSingleEnable();
    testFallThrough();
    testOrder();
    testReadEmpty();
    testFillDefaults();
    testOffsets();
    testOutEn();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule